// File: doc/BRIEF.md
# Multi-State Trigger Sequencer

This block sits behind the pattern matchers of an on-chip logic analyzer. It decides when capture begins and ends, and when the trigger is raised. The block has four states, and each state holds two programmable condition/action entries. On every sampled cycle the entries of the current state are evaluated. The first enabled entry whose condition is true carries out its actions. An action can raise the trigger, start, stop or single-step the trace, drive a trigger-out line, control a 32-bit event counter/timer, or jump to another state.

A condition takes the AND of a chosen subset of the match flags. It can also require that the counter has reached a programmed limit. Together with the state the entry belongs to, this lets the analyzer arm in stages: it can wait for an address hit, then count a number of data hits or clocks, and only then trigger.

Software programs the table through a simple write port, one entry word per write. The counter limit and the counter mode are loaded through a separate control write. A re-arm pulse restarts the sequencer and keeps the programmed table.

Top module: `trig_seq`

## Requirements
- R1: After reset or a re-arm pulse: state_o is 0, trig_o, trace_start_o, trace_stop_o, trace_single_o and trig_out_o are 0, the counter is 0 and stopped. Re-arm keeps the programmed entries, the limit and the mode.
- R2: A table write stores cfg_word_i into entry cfg_entry_i of state cfg_state_i on the clock edge. Field positions with defaults of 8 match flags and 4 states: bits 7:0 match mask, bit 8 use-counter, bit 9 trigger, bits 11:10 trace code, bits 13:12 trigger-out code, bits 16:14 counter code, bit 17 goto enable, bits 19:18 goto state, bit 20 entry enable. An entry with its enable bit at 0 never fires.
- R3: An entry's condition is true when sample_en_i is 1, the entry is enabled, every match_i bit selected by its mask is 1, and, if use-counter is set, the counter is at or above the limit. With sample_en_i at 0 nothing fires.
- R4: Only one entry fires per cycle. When both entries of the current state are true, entry 0 fires and entry 1 does not.
- R5: A firing entry with goto enable set moves state_o to its goto state on the next edge. Otherwise the state is unchanged.
- R6: A firing entry with the trigger bit set raises trig_o on the next edge. trig_o then stays 1 until re-arm or reset.
- R7: Trace code 1 gives a one-cycle trace_start_o, code 2 a one-cycle trace_stop_o, code 3 a one-cycle trace_single_o, and code 0 does nothing. Each pulse appears in the cycle after the firing edge.
- R8: Trigger-out code 1 drives trig_out_o high for exactly one cycle. Code 2 holds it high until changed. Code 3 drives it low. Code 0 leaves it as it is.
- R9: In timer mode (cfg_timer_i=1 at the control write) the counter starts on counter code 2 and stops on code 3. While started, it adds one on every clock, beginning with the edge after the start edge.
- R10: In event mode the counter adds one only when an entry fires with counter code 1. Counter code 4 clears it to 0 in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rearm_i | input | 1 | Synchronous restart of state, counter and outputs |
| sample_en_i | input | 1 | Qualifies the cycle for condition evaluation |
| match_i | input | N_MATCH | Event match flags from the pattern matchers |
| cfg_we_i | input | 1 | Table entry write strobe |
| cfg_state_i | input | STATE_W | State addressed by the write |
| cfg_entry_i | input | ENT_W | Entry addressed by the write |
| cfg_word_i | input | CFG_W | Entry contents |
| cfg_ctl_we_i | input | 1 | Counter limit/mode write strobe |
| cfg_limit_i | input | CNT_W | Counter compare limit |
| cfg_timer_i | input | 1 | 1 = timer mode, 0 = event mode |
| trig_o | output | 1 | Latched trigger |
| trace_start_o | output | 1 | Trace start pulse |
| trace_stop_o | output | 1 | Trace stop pulse |
| trace_single_o | output | 1 | Trace single-sample pulse |
| trig_out_o | output | 1 | External trigger-out line |
| state_o | output | STATE_W | Current sequencer state |

## Verification
Matches are driven with one mask bit, with both of two mask bits, and with only one of two mask bits. This separates a true AND from an OR or from ignoring the mask. Both entries of a state are made true at once to show that entry 0 wins and that its counter action alone takes effect. The counter is exercised in three ways: free-running in timer mode, with the trigger edge expected on an exact cycle; by counted increments in event mode; and across a clear. These tell a start-to-count off-by-one apart from a compare that uses greater-than where it should use at-or-above. Trigger-out is driven through pulse, assert, hold and negate so that a pulse can be told apart from a level.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  typedef enum logic [1:0] {
    TRC_NONE   = 2'd0,
    TRC_START  = 2'd1,
    TRC_STOP   = 2'd2,
    TRC_SINGLE = 2'd3
  } trace_act_e;

  typedef enum logic [1:0] {
    TOUT_NONE   = 2'd0,
    TOUT_PULSE  = 2'd1,
    TOUT_ASSERT = 2'd2,
    TOUT_NEGATE = 2'd3
  } tout_act_e;

  typedef enum logic [2:0] {
    CNT_NONE  = 3'd0,
    CNT_INC   = 3'd1,
    CNT_START = 3'd2,
    CNT_STOP  = 3'd3,
    CNT_CLEAR = 3'd4
  } cnt_act_e;

  typedef struct packed {
    logic       fire;
    logic       trig;
    trace_act_e trace;
    tout_act_e  tout;
    cnt_act_e   cnt;
  } act_t;

endpackage

// File: rtl/trig_seq_cfg.sv
module trig_seq_cfg #(
  parameter int N_STATES  = 4,
  parameter int N_ENTRIES = 2,
  parameter int CFG_W     = 21,
  parameter int CNT_W     = 32,
  localparam int STATE_W  = $clog2(N_STATES),
  localparam int ENT_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [STATE_W-1:0]              wr_state_i,
  input  logic [ENT_W-1:0]                wr_entry_i,
  input  logic [CFG_W-1:0]                wr_word_i,
  input  logic                            ctl_we_i,
  input  logic [CNT_W-1:0]                limit_i,
  input  logic                            timer_i,
  input  logic [STATE_W-1:0]              rd_state_i,
  output logic [N_ENTRIES-1:0][CFG_W-1:0] row_o,
  output logic [CNT_W-1:0]                limit_o,
  output logic                            timer_o
);

  logic [CFG_W-1:0] tbl_q [N_STATES][N_ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_STATES; s++)
        for (int e = 0; e < N_ENTRIES; e++)
          tbl_q[s][e] <= '0;
    end else if (we_i) begin
      tbl_q[wr_state_i][wr_entry_i] <= wr_word_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_o <= '0;
      timer_o <= 1'b0;
    end else if (ctl_we_i) begin
      limit_o <= limit_i;
      timer_o <= timer_i;
    end
  end

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_row
    assign row_o[e] = tbl_q[rd_state_i][e];
  end

endmodule

// File: rtl/trig_seq_eval.sv
module trig_seq_eval
  import trig_seq_pkg::*;
#(
  parameter int N_MATCH   = 8,
  parameter int N_ENTRIES = 2,
  parameter int STATE_W   = 2,
  parameter int CNT_W     = 32,
  parameter int CFG_W     = 21
) (
  input  logic [N_ENTRIES-1:0][CFG_W-1:0] row_i,
  input  logic                            sample_en_i,
  input  logic [N_MATCH-1:0]              match_i,
  input  logic [CNT_W-1:0]                cnt_i,
  input  logic [CNT_W-1:0]                limit_i,
  output act_t                            act_o,
  output logic                            goto_en_o,
  output logic [STATE_W-1:0]              goto_st_o
);

  localparam int L_USE  = N_MATCH;
  localparam int L_TRIG = N_MATCH + 1;
  localparam int L_TRC  = N_MATCH + 2;
  localparam int L_TOUT = N_MATCH + 4;
  localparam int L_CNT  = N_MATCH + 6;
  localparam int L_GEN  = N_MATCH + 9;
  localparam int L_GST  = N_MATCH + 10;
  localparam int L_EN   = N_MATCH + 10 + STATE_W;

  logic [N_ENTRIES-1:0] hit;
  logic                 cnt_ge;

  assign cnt_ge = (cnt_i >= limit_i);

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_hit
    logic [N_MATCH-1:0] mask;
    assign mask   = row_i[e][N_MATCH-1:0];
    assign hit[e] = sample_en_i && row_i[e][L_EN]
                 && ((match_i & mask) == mask)
                 && (!row_i[e][L_USE] || cnt_ge);
  end

  // lowest index wins
  logic [CFG_W-1:0] sel_w;
  always_comb begin
    sel_w = '0;
    for (int e = N_ENTRIES - 1; e >= 0; e--)
      if (hit[e]) sel_w = row_i[e];
  end

  always_comb begin
    act_o.fire  = |hit;
    act_o.trig  = sel_w[L_TRIG];
    act_o.trace = trace_act_e'(sel_w[L_TRC+:2]);
    act_o.tout  = tout_act_e'(sel_w[L_TOUT+:2]);
    act_o.cnt   = cnt_act_e'(sel_w[L_CNT+:3]);
    goto_en_o   = sel_w[L_GEN];
    goto_st_o   = sel_w[L_GST+:STATE_W];
  end

endmodule

// File: rtl/trig_seq_cnt.sv
module trig_seq_cnt
  import trig_seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rearm_i,
  input  logic             timer_i,
  input  logic             fire_i,
  input  cnt_act_e         act_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic run_q;
  logic step;

  assign step = timer_i ? run_q : (fire_i && act_i == CNT_INC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      run_q <= 1'b0;
    end else if (rearm_i) begin
      cnt_o <= '0;
      run_q <= 1'b0;
    end else begin
      if (fire_i && act_i == CNT_START)     run_q <= 1'b1;
      else if (fire_i && act_i == CNT_STOP) run_q <= 1'b0;
      if (fire_i && act_i == CNT_CLEAR) cnt_o <= '0;
      else if (step)                    cnt_o <= cnt_o + 1'b1;
    end
  end

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int N_MATCH   = 8,
  parameter int N_STATES  = 4,
  parameter int N_ENTRIES = 2,
  parameter int CNT_W     = 32,
  localparam int STATE_W  = $clog2(N_STATES),
  localparam int ENT_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int CFG_W    = N_MATCH + STATE_W + 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rearm_i,
  input  logic               sample_en_i,
  input  logic [N_MATCH-1:0] match_i,
  input  logic               cfg_we_i,
  input  logic [STATE_W-1:0] cfg_state_i,
  input  logic [ENT_W-1:0]   cfg_entry_i,
  input  logic [CFG_W-1:0]   cfg_word_i,
  input  logic               cfg_ctl_we_i,
  input  logic [CNT_W-1:0]   cfg_limit_i,
  input  logic               cfg_timer_i,
  output logic               trig_o,
  output logic               trace_start_o,
  output logic               trace_stop_o,
  output logic               trace_single_o,
  output logic               trig_out_o,
  output logic [STATE_W-1:0] state_o
);

  logic [N_ENTRIES-1:0][CFG_W-1:0] row;
  logic [CNT_W-1:0]                limit, cnt;
  logic                            timer_mode;
  act_t                            act;
  logic                            goto_en;
  logic [STATE_W-1:0]              goto_st;
  logic                            tout_lvl_q, tout_pls_q;

  trig_seq_cfg #(
    .N_STATES (N_STATES),
    .N_ENTRIES(N_ENTRIES),
    .CFG_W    (CFG_W),
    .CNT_W    (CNT_W)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .wr_state_i(cfg_state_i),
    .wr_entry_i(cfg_entry_i),
    .wr_word_i (cfg_word_i),
    .ctl_we_i  (cfg_ctl_we_i),
    .limit_i   (cfg_limit_i),
    .timer_i   (cfg_timer_i),
    .rd_state_i(state_o),
    .row_o     (row),
    .limit_o   (limit),
    .timer_o   (timer_mode)
  );

  trig_seq_eval #(
    .N_MATCH  (N_MATCH),
    .N_ENTRIES(N_ENTRIES),
    .STATE_W  (STATE_W),
    .CNT_W    (CNT_W),
    .CFG_W    (CFG_W)
  ) u_eval (
    .row_i      (row),
    .sample_en_i(sample_en_i),
    .match_i    (match_i),
    .cnt_i      (cnt),
    .limit_i    (limit),
    .act_o      (act),
    .goto_en_o  (goto_en),
    .goto_st_o  (goto_st)
  );

  trig_seq_cnt #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rearm_i(rearm_i),
    .timer_i(timer_mode),
    .fire_i (act.fire),
    .act_i  (act.cnt),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o        <= '0;
      trig_o         <= 1'b0;
      trace_start_o  <= 1'b0;
      trace_stop_o   <= 1'b0;
      trace_single_o <= 1'b0;
      tout_lvl_q     <= 1'b0;
      tout_pls_q     <= 1'b0;
    end else if (rearm_i) begin
      state_o        <= '0;
      trig_o         <= 1'b0;
      trace_start_o  <= 1'b0;
      trace_stop_o   <= 1'b0;
      trace_single_o <= 1'b0;
      tout_lvl_q     <= 1'b0;
      tout_pls_q     <= 1'b0;
    end else begin
      if (act.fire && goto_en) state_o <= goto_st;
      if (act.fire && act.trig) trig_o <= 1'b1;
      trace_start_o  <= act.fire && act.trace == TRC_START;
      trace_stop_o   <= act.fire && act.trace == TRC_STOP;
      trace_single_o <= act.fire && act.trace == TRC_SINGLE;
      tout_pls_q     <= act.fire && act.tout == TOUT_PULSE;
      if (act.fire && act.tout == TOUT_ASSERT)      tout_lvl_q <= 1'b1;
      else if (act.fire && act.tout == TOUT_NEGATE) tout_lvl_q <= 1'b0;
    end
  end

  assign trig_out_o = tout_lvl_q | tout_pls_q;

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk #(
  parameter int STATE_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rearm_i,
  input logic               sample_en_i,
  input logic               trig_o,
  input logic               trace_start_o,
  input logic               trace_stop_o,
  input logic               trace_single_o,
  input logic               trig_out_o,
  input logic [STATE_W-1:0] state_o
);

  assert_rearm_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> (state_o == '0) && !trig_o && !trig_out_o
                && !trace_start_o && !trace_stop_o && !trace_single_o);

  assert_idle_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_en_i && !rearm_i) |=> $stable(state_o));

  assert_idle_trace_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> !trace_start_o && !trace_stop_o && !trace_single_o);

  assert_trig_latched_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_o && !rearm_i) |=> trig_o);

  assert_trace_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({trace_start_o, trace_stop_o, trace_single_o}));

endmodule

bind trig_seq trig_seq_chk #(.STATE_W(STATE_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rearm_i       (rearm_i),
  .sample_en_i   (sample_en_i),
  .trig_o        (trig_o),
  .trace_start_o (trace_start_o),
  .trace_stop_o  (trace_stop_o),
  .trace_single_o(trace_single_o),
  .trig_out_o    (trig_out_o),
  .state_o       (state_o)
);

// File: tb/trig_seq_bench.sv
`timescale 1ns/1ps
module trig_seq_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rearm_i = 1'b0;
  logic        sample_en_i = 1'b0;
  logic [7:0]  match_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_state_i = '0;
  logic [0:0]  cfg_entry_i = '0;
  logic [20:0] cfg_word_i = '0;
  logic        cfg_ctl_we_i = 1'b0;
  logic [31:0] cfg_limit_i = '0;
  logic        cfg_timer_i = 1'b0;
  logic        trig_o, trace_start_o, trace_stop_o, trace_single_o, trig_out_o;
  logic [1:0]  state_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  trig_seq u_trig_seq (.*);

  function automatic logic [20:0] mk(input bit en, input int gst, input bit gen,
                                     input int cnt, input int tout, input int trc,
                                     input bit trg, input bit usec, input int mask);
    logic [20:0] w;
    w = '0;
    w[7:0]   = mask[7:0];
    w[8]     = usec;
    w[9]     = trg;
    w[11:10] = trc[1:0];
    w[13:12] = tout[1:0];
    w[16:14] = cnt[2:0];
    w[17]    = gen;
    w[19:18] = gst[1:0];
    w[20]    = en;
    return w;
  endfunction

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int st, input int ent, input logic [20:0] w);
    cfg_we_i = 1'b1; cfg_state_i = st[1:0]; cfg_entry_i = ent[0:0]; cfg_word_i = w;
    tick();
    cfg_we_i = 1'b0;
  endtask

  task automatic ctl(input int lim, input bit tmr);
    cfg_ctl_we_i = 1'b1; cfg_limit_i = lim; cfg_timer_i = tmr;
    tick();
    cfg_ctl_we_i = 1'b0;
  endtask

  task automatic clear_all();
    sample_en_i = 1'b0; match_i = '0;
    for (int s = 0; s < 4; s++)
      for (int e = 0; e < 2; e++) wr(s, e, '0);
  endtask

  task automatic rearm();
    sample_en_i = 1'b0; match_i = '0; rearm_i = 1'b1;
    tick();
    rearm_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "state after reset", state_o, 0);
    chk("R1", "trig after reset", trig_o, 0);
    chk("R1", "trig_out after reset", trig_out_o, 0);
    chk("R1", "trace pulses after reset",
        {trace_start_o, trace_stop_o, trace_single_o}, 0);
  endtask

  task automatic t_condition();
    clear_all();
    wr(0, 0, mk(0, 1, 1, 0, 0, 0, 1, 0, 0));  // disabled, always-true mask
    rearm();
    sample_en_i = 1'b1; tick();
    chk("R2", "disabled entry trig", trig_o, 0);
    sample_en_i = 1'b0;
    wr(0, 0, mk(1, 1, 1, 0, 0, 0, 1, 0, 8'h03));
    match_i = 8'h03; tick(); tick();
    chk("R3", "no sample_en trig", trig_o, 0);
    chk("R3", "no sample_en state", state_o, 0);
    sample_en_i = 1'b1; match_i = 8'h01; tick();
    chk("R3", "partial mask trig", trig_o, 0);
    match_i = 8'h03; tick();
    chk("R3", "full mask trig", trig_o, 1);
    chk("R5", "goto state 1", state_o, 1);
    sample_en_i = 1'b0; match_i = '0; tick(); tick();
    chk("R6", "trig latched", trig_o, 1);
    rearm();
    chk("R1", "rearm trig", trig_o, 0);
    chk("R1", "rearm state", state_o, 0);
  endtask

  task automatic t_timer();
    clear_all();
    ctl(5, 1'b1);
    wr(0, 0, mk(1, 1, 1, 2, 0, 0, 0, 0, 0));      // start counter, goto 1
    wr(1, 0, mk(1, 2, 1, 0, 0, 0, 1, 1, 0));      // cnt>=5 -> trig, goto 2
    rearm();
    sample_en_i = 1'b1; tick();
    chk("R9", "state after start", state_o, 1);
    for (int i = 1; i <= 5; i++) begin
      tick();
      chk("R9", "trig before limit", trig_o, 0);
    end
    tick();
    chk("R9", "trig at limit", trig_o, 1);
    chk("R5", "goto state 2", state_o, 2);
    rearm();
  endtask

  task automatic t_event();
    clear_all();
    ctl(2, 1'b0);
    wr(0, 0, mk(1, 0, 0, 1, 0, 0, 0, 0, 8'h01));  // match0 -> inc
    wr(0, 1, mk(1, 3, 1, 0, 0, 0, 1, 1, 0));      // cnt>=2 -> trig, goto 3
    rearm();
    sample_en_i = 1'b1; tick();
    chk("R1", "counter cleared by rearm", trig_o, 0);
    match_i = 8'h01;
    tick(); tick();
    chk("R10", "trig after two incs while entry0 true", trig_o, 0);
    tick();
    chk("R4", "entry0 priority trig", trig_o, 0);
    chk("R4", "entry0 priority state", state_o, 0);
    match_i = 8'h00; tick();
    chk("R10", "trig after count reached", trig_o, 1);
    chk("R10", "goto state 3", state_o, 3);
    // clear
    clear_all();
    ctl(1, 1'b0);
    wr(0, 0, mk(1, 0, 0, 1, 0, 0, 0, 0, 8'h01));
    wr(0, 1, mk(1, 1, 1, 4, 0, 0, 0, 0, 8'h02));  // clear, goto 1
    wr(1, 0, mk(1, 0, 0, 0, 0, 0, 1, 1, 0));
    rearm();
    sample_en_i = 1'b1; match_i = 8'h01; tick(); tick();
    match_i = 8'h02; tick();
    chk("R10", "state after clear entry", state_o, 1);
    match_i = 8'h00; tick();
    chk("R10", "no trig after clear", trig_o, 0);
    rearm();
  endtask

  task automatic t_outputs();
    clear_all();
    wr(0, 0, mk(1, 0, 0, 0, 1, 1, 0, 0, 8'h02));  // pulse, start
    wr(0, 1, mk(1, 0, 0, 0, 2, 2, 0, 0, 8'h04));  // assert, stop
    rearm();
    sample_en_i = 1'b1; match_i = 8'h02; tick();
    chk("R8", "pulse high", trig_out_o, 1);
    chk("R7", "trace start", trace_start_o, 1);
    chk("R7", "trace stop idle", trace_stop_o, 0);
    match_i = 8'h00; tick();
    chk("R8", "pulse one cycle", trig_out_o, 0);
    chk("R7", "start one cycle", trace_start_o, 0);
    match_i = 8'h04; tick();
    chk("R8", "assert high", trig_out_o, 1);
    chk("R7", "trace stop", trace_stop_o, 1);
    match_i = 8'h00; tick(); tick();
    chk("R8", "assert held", trig_out_o, 1);
    chk("R7", "stop one cycle", trace_stop_o, 0);
    sample_en_i = 1'b0;
    wr(0, 0, mk(1, 0, 0, 0, 3, 3, 0, 0, 8'h08));  // negate, single
    sample_en_i = 1'b1; match_i = 8'h08; tick();
    chk("R8", "negate low", trig_out_o, 0);
    chk("R7", "trace single", trace_single_o, 1);
    match_i = 8'h04; tick();
    match_i = 8'h00;
    rearm();
    chk("R1", "rearm negates trig_out", trig_out_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_condition();
    t_timer();
    t_event();
    t_outputs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule